// File: doc/BRIEF.md
# Cable Reflectometry Test Sequencer

This block schedules a cable test on a single-pair Ethernet line. Software arms it by writing the start bit of the control word. The sequencer then moves through a fixed schedule. It keeps the line quiet for a selectable time and then enables the modulated probe transmitter for a programmable number of microseconds. After a second quiet time it hands the line over to forced-link operation, with no autonegotiation. During the probe window it drives a transmit-enable and a level-select output toward the analog front end. An external correlator searches for reflection peaks and supplies the result. The sequencer latches that result into a readable word when the probe window closes.

The states are IDLE, PRE (pre-probe silence), PROBE (modulated transmit), POST (post-probe silence) and LINK (forced link). There are six transitions:
- IDLE->PRE and LINK->PRE on an accepted start.
- PRE->PROBE when the pre-silence time expires.
- PRE->IDLE (abort) when line activity is seen during pre-silence.
- PROBE->POST when the probe time expires, which also captures the result.
- POST->LINK when the post-silence time expires.

LINK is held until the next start. A prescaler makes a 1 µs tick from the system clock. Each millisecond of silence is a parameterised number of ticks, 1000 by default.

Top module: `ctst_seq`

## Requirements
- R1: After reset the register words read as follows:
  - control (address 0): 0
  - timing (address 1): 0
  - probe length (address 2): 16000
  - tap window (address 3): 0x2404
  - fault configuration (address 4): 0x043E
  - result (address 5): 0

  After reset the phase output is IDLE (0), and tx_en, amp_sel, forced_link, test_done and test_fail are 0.
- R2: Writing control with bit 15 set while the phase is IDLE or LINK is accepted. The control word reads with bit 15 set in the cycle after the write. The phase becomes PRE (1) one cycle later, and bit 15 then reads 0. Phases always run in the order PRE, PROBE (2), POST (3), LINK (4).
- R3: The timing word holds the pre-silence code in bits 1:0 and the post-silence code in bits 3:2. Codes 0, 1, 2 and 3 select 0, 10, 100 and 1000 ms. A silence phase lasts ms × US_PER_MS × CLK_PER_US cycles, or 1 cycle when the code is 0.
- R4: The PROBE phase lasts probe_length × CLK_PER_US cycles, or 1 cycle when the length is 0. tx_en is 1 exactly during PROBE.
- R5: During PROBE, amp_sel equals bit 4 of the timing word: 0 selects the 1 V level and 1 selects the 2.4 V level. Outside PROBE, amp_sel is 0.
- R6: The result word is sampled from the correlator inputs in the last PROBE cycle. It holds the detect flag in bit 11, the sign flag in bit 10 and the location in bits 9:0. A detected peak with the sign set is an open, and with the sign clear it is a short. Later changes of the correlator inputs leave the word unchanged.
- R7: test_done (control bit 1) rises on entry to POST, with test_fail (control bit 0) at 0. forced_link is 1 from the end of POST until the next start.
- R8: A start written during PRE, PROBE or POST is ignored. The phase timing and the done flag are unaffected.
- R9: An accepted start clears done, fail and the result word.
- R10: line_active during PRE aborts the test. The next phase is IDLE, done and fail are both 1, and the result stays 0. line_active in any other phase has no effect.
- R11: The tap window word holds the start tap in bits 6:0 and the end tap in bits 14:8. The fault configuration word holds the threshold in bits 7:0 and the location offset in bits 14:8. Each field is driven on its own output, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| line_active | input | 1 | Line activity detected by the receiver |
| pk_detect | input | 1 | Correlator: peak found |
| pk_sign | input | 1 | Correlator: peak polarity |
| pk_loc | input | 10 | Correlator: peak location |
| phase | output | 3 | Current phase: 0 IDLE, 1 PRE, 2 PROBE, 3 POST, 4 LINK |
| tx_en | output | 1 | Probe transmitter enable |
| amp_sel | output | 1 | Probe level select |
| forced_link | output | 1 | Forced-link operation active |
| test_done | output | 1 | Test finished |
| test_fail | output | 1 | Test aborted |
| tap_first | output | 7 | Start tap index to the correlator |
| tap_last | output | 7 | End tap index to the correlator |
| flt_offset | output | 7 | Location offset to the correlator |
| flt_thresh | output | 8 | Initial threshold to the correlator |

## Verification
A scoreboard measures every phase in cycles against the length computed from the programmed codes, including the 1-cycle zero-length phases and the 1000 ms code. A design that miscounts ticks, or that does not restart the prescaler at each phase entry, would be off by a cycle or more. The bench changes the correlator inputs right after the probe window and writes start during a running test. A design that samples late or restarts mid-test would report the wrong word or phase lengths. An abort in the middle of pre-silence must yield done together with fail and a cleared result. Line activity during the probe must leave the schedule untouched, so a design that checks the abort input in every phase would be caught.

// File: rtl/ctst_pkg.sv
package ctst_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;
    localparam int TAP_W  = 7;
    localparam int THR_W  = 8;
    localparam int LOC_W  = 10;
    localparam int RES_W  = LOC_W + 2;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PRE   = 3'd1,
        PH_PROBE = 3'd2,
        PH_POST  = 3'd3,
        PH_LINK  = 3'd4
    } ctst_phase_e;

    // word addresses
    localparam logic [ADDR_W-1:0] A_CTL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TIME = 3'd1;
    localparam logic [ADDR_W-1:0] A_PLEN = 3'd2;
    localparam logic [ADDR_W-1:0] A_TAPS = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_RES  = 3'd5;

    // control word bits
    localparam int CTL_GO_BIT   = 15;
    localparam int CTL_DONE_BIT = 1;
    localparam int CTL_FAIL_BIT = 0;

    // timing word layout
    localparam int TM_PRE_LSB  = 0;
    localparam int TM_POST_LSB = 2;
    localparam int TM_AMP_BIT  = 4;

    // defaults
    localparam logic [DATA_W-1:0] PLEN_RST   = 16'd16000;
    localparam logic [TAP_W-1:0]  TAP_LO_RST = 7'd4;
    localparam logic [TAP_W-1:0]  TAP_HI_RST = 7'd36;
    localparam logic [TAP_W-1:0]  OFF_RST    = 7'd4;
    localparam logic [THR_W-1:0]  THR_RST    = 8'd62;

    function automatic int unsigned quiet_ms(input logic [1:0] code);
        case (code)
            2'd0:    return 0;
            2'd1:    return 10;
            2'd2:    return 100;
            default: return 1000;
        endcase
    endfunction

endpackage

// File: rtl/ctst_tick.sv
module ctst_tick #(
    parameter int CLK_PER_US = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

    logic [PW-1:0] pcnt;

    assign tick = (pcnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (clr || tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/ctst_regs.sv
module ctst_regs
    import ctst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  logic              launch,
    input  logic              ev_abort,
    input  logic              ev_done,
    input  logic              ev_capture,
    input  logic [RES_W-1:0]  cap_word,
    output logic              go_pend,
    output logic [1:0]        pre_code,
    output logic [1:0]        post_code,
    output logic              amp_cfg,
    output logic [DATA_W-1:0] probe_len,
    output logic [TAP_W-1:0]  tap_lo,
    output logic [TAP_W-1:0]  tap_hi,
    output logic [TAP_W-1:0]  loc_off,
    output logic [THR_W-1:0]  thresh,
    output logic              done,
    output logic              fail,
    output logic [RES_W-1:0]  result
);
    logic go_accept;

    assign go_accept = wr && (addr == A_CTL) && wdata[CTL_GO_BIT] && !busy;

    // status and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_pend <= 1'b0;
            done    <= 1'b0;
            fail    <= 1'b0;
            result  <= '0;
        end else begin
            if (go_accept) begin
                go_pend <= 1'b1;
                done    <= 1'b0;
                fail    <= 1'b0;
                result  <= '0;
            end else begin
                if (launch)
                    go_pend <= 1'b0;
                if (ev_capture)
                    result <= cap_word;
                if (ev_done)
                    done <= 1'b1;
                if (ev_abort) begin
                    done <= 1'b1;
                    fail <= 1'b1;
                end
            end
        end
    end

    // configuration words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_code  <= 2'd0;
            post_code <= 2'd0;
            amp_cfg   <= 1'b0;
            probe_len <= PLEN_RST;
            tap_lo    <= TAP_LO_RST;
            tap_hi    <= TAP_HI_RST;
            loc_off   <= OFF_RST;
            thresh    <= THR_RST;
        end else if (wr) begin
            case (addr)
                A_TIME: begin
                    pre_code  <= wdata[TM_PRE_LSB +: 2];
                    post_code <= wdata[TM_POST_LSB +: 2];
                    amp_cfg   <= wdata[TM_AMP_BIT];
                end
                A_PLEN: probe_len <= wdata;
                A_TAPS: begin
                    tap_lo <= wdata[0 +: TAP_W];
                    tap_hi <= wdata[8 +: TAP_W];
                end
                A_FLT: begin
                    thresh  <= wdata[0 +: THR_W];
                    loc_off <= wdata[8 +: TAP_W];
                end
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTL: begin
                rdata[CTL_GO_BIT]   = go_pend;
                rdata[CTL_DONE_BIT] = done;
                rdata[CTL_FAIL_BIT] = fail;
            end
            A_TIME: begin
                rdata[TM_PRE_LSB +: 2]  = pre_code;
                rdata[TM_POST_LSB +: 2] = post_code;
                rdata[TM_AMP_BIT]       = amp_cfg;
            end
            A_PLEN: rdata = probe_len;
            A_TAPS: begin
                rdata[0 +: TAP_W] = tap_lo;
                rdata[8 +: TAP_W] = tap_hi;
            end
            A_FLT: begin
                rdata[0 +: THR_W] = thresh;
                rdata[8 +: TAP_W] = loc_off;
            end
            A_RES:   rdata[0 +: RES_W] = result;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ctst_fsm.sv
module ctst_fsm
    import ctst_pkg::*;
#(
    parameter int US_PER_MS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go_pend,
    input  logic [1:0]        pre_code,
    input  logic [1:0]        post_code,
    input  logic [DATA_W-1:0] probe_len,
    input  logic              amp_cfg,
    input  logic              line_active,
    output ctst_phase_e       state,
    output logic              tick_clr,
    output logic              launch,
    output logic              ev_abort,
    output logic              ev_done,
    output logic              ev_capture,
    output logic              busy,
    output logic              tx_en,
    output logic              amp_sel,
    output logic              forced_link
);
    localparam int MAX_QUIET = 1000 * US_PER_MS;
    localparam int MAX_TICKS = (MAX_QUIET > 65535) ? MAX_QUIET : 65535;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    ctst_phase_e      nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;
    logic             load;
    logic             expire;

    function automatic logic [CNT_W-1:0] quiet_ticks(input logic [1:0] code);
        return CNT_W'(quiet_ms(code) * US_PER_MS);
    endfunction

    assign expire = (cnt == '0) || (tick && (cnt == CNT_W'(1)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= PH_IDLE;
        else
            state <= nxt;
    end

    // phase timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    // transitions
    always_comb begin
        nxt        = state;
        load       = 1'b0;
        load_val   = '0;
        launch     = 1'b0;
        ev_abort   = 1'b0;
        ev_done    = 1'b0;
        ev_capture = 1'b0;
        unique case (state)
            PH_IDLE, PH_LINK: begin
                if (go_pend) begin
                    nxt      = PH_PRE;
                    load     = 1'b1;
                    load_val = quiet_ticks(pre_code);
                    launch   = 1'b1;
                end
            end
            PH_PRE: begin
                if (line_active) begin
                    nxt      = PH_IDLE;
                    ev_abort = 1'b1;
                end else if (expire) begin
                    nxt      = PH_PROBE;
                    load     = 1'b1;
                    load_val = CNT_W'(probe_len);
                end
            end
            PH_PROBE: begin
                if (expire) begin
                    nxt        = PH_POST;
                    load       = 1'b1;
                    load_val   = quiet_ticks(post_code);
                    ev_capture = 1'b1;
                    ev_done    = 1'b1;
                end
            end
            PH_POST: begin
                if (expire)
                    nxt = PH_LINK;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    assign tick_clr = load;

    // outputs
    always_comb begin
        tx_en       = 1'b0;
        amp_sel     = 1'b0;
        forced_link = 1'b0;
        busy        = 1'b0;
        unique case (state)
            PH_PRE:   busy = 1'b1;
            PH_PROBE: begin
                busy    = 1'b1;
                tx_en   = 1'b1;
                amp_sel = amp_cfg;
            end
            PH_POST:  busy = 1'b1;
            PH_LINK:  forced_link = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/ctst_seq.sv
module ctst_seq
    import ctst_pkg::*;
#(
    parameter int CLK_PER_US = 250,
    parameter int US_PER_MS  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              line_active,
    input  logic              pk_detect,
    input  logic              pk_sign,
    input  logic [LOC_W-1:0]  pk_loc,
    output logic [2:0]        phase,
    output logic              tx_en,
    output logic              amp_sel,
    output logic              forced_link,
    output logic              test_done,
    output logic              test_fail,
    output logic [TAP_W-1:0]  tap_first,
    output logic [TAP_W-1:0]  tap_last,
    output logic [TAP_W-1:0]  flt_offset,
    output logic [THR_W-1:0]  flt_thresh
);
    logic              tick, tick_clr, launch, busy;
    logic              ev_abort, ev_done, ev_capture, go_pend;
    logic [1:0]        pre_code, post_code;
    logic              amp_cfg;
    logic [DATA_W-1:0] probe_len;
    logic [RES_W-1:0]  res_word;
    logic [RES_W-1:0]  cap_word;
    ctst_phase_e       state;

    assign cap_word = {pk_detect, pk_sign, pk_loc};
    assign phase    = state;

    ctst_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    ctst_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (reg_addr),
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .busy       (busy),
        .launch     (launch),
        .ev_abort   (ev_abort),
        .ev_done    (ev_done),
        .ev_capture (ev_capture),
        .cap_word   (cap_word),
        .go_pend    (go_pend),
        .pre_code   (pre_code),
        .post_code  (post_code),
        .amp_cfg    (amp_cfg),
        .probe_len  (probe_len),
        .tap_lo     (tap_first),
        .tap_hi     (tap_last),
        .loc_off    (flt_offset),
        .thresh     (flt_thresh),
        .done       (test_done),
        .fail       (test_fail),
        .result     (res_word)
    );

    ctst_fsm #(.US_PER_MS(US_PER_MS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .go_pend     (go_pend),
        .pre_code    (pre_code),
        .post_code   (post_code),
        .probe_len   (probe_len),
        .amp_cfg     (amp_cfg),
        .line_active (line_active),
        .state       (state),
        .tick_clr    (tick_clr),
        .launch      (launch),
        .ev_abort    (ev_abort),
        .ev_done     (ev_done),
        .ev_capture  (ev_capture),
        .busy        (busy),
        .tx_en       (tx_en),
        .amp_sel     (amp_sel),
        .forced_link (forced_link)
    );
endmodule

// File: rtl/ctst_seq_chk.sv
module ctst_seq_chk
    import ctst_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       phase,
    input logic             tx_en,
    input logic             forced_link,
    input logic             test_done,
    input logic             test_fail,
    input logic [RES_W-1:0] res_word
);
    // R2
    probe_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PROBE && $past(phase) != PH_PROBE) |-> $past(phase) == PH_PRE);

    // R4
    tx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(phase) == PH_PRE);

    // R7
    done_on_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_POST && $past(phase) == PH_PROBE) |-> (test_done && !test_fail));

    // R7
    link_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(forced_link) |-> $past(phase) == PH_POST);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_POST && $past(phase) == PH_POST) |-> $stable(res_word));

    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PRE && $past(phase) != PH_PRE) |-> (!test_done && !test_fail && res_word == '0));

    // R10
    abort_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_PRE && phase == PH_IDLE) |-> (test_done && test_fail && res_word == '0));
endmodule

bind ctst_seq ctst_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .tx_en       (tx_en),
    .forced_link (forced_link),
    .test_done   (test_done),
    .test_fail   (test_fail),
    .res_word    (res_word)
);

// File: tb/tb_ctst_seq.sv
`timescale 1ns/1ps
module tb_ctst_seq;
    import ctst_pkg::*;

    localparam int CPU = 2;
    localparam int UPM = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        line_active = 1'b0;
    logic        pk_detect = 1'b0;
    logic        pk_sign = 1'b0;
    logic [9:0]  pk_loc = '0;
    logic [2:0]  phase;
    logic        tx_en, amp_sel, forced_link, test_done, test_fail;
    logic [6:0]  tap_first, tap_last, flt_offset;
    logic [7:0]  flt_thresh;

    always #2 clk = ~clk;

    ctst_seq #(.CLK_PER_US(CPU), .US_PER_MS(UPM)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_active(line_active),
        .pk_detect(pk_detect), .pk_sign(pk_sign), .pk_loc(pk_loc), .phase(phase),
        .tx_en(tx_en), .amp_sel(amp_sel), .forced_link(forced_link),
        .test_done(test_done), .test_fail(test_fail), .tap_first(tap_first),
        .tap_last(tap_last), .flt_offset(flt_offset), .flt_thresh(flt_thresh)
    );

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int ph;
        int len;
    } item_t;
    item_t expq[$];
    logic exp_amp = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int quiet_cyc(input int code);
        int ms;
        ms = (code == 0) ? 0 : (code == 1) ? 10 : (code == 2) ? 100 : 1000;
        return (ms == 0) ? 1 : ms * UPM * CPU;
    endfunction

    function automatic int probe_cyc(input int len);
        return (len == 0) ? 1 : len * CPU;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr  = 3'(a);
        reg_wdata = 16'(d);
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 3'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic wait_phase(input int p);
        while (int'(phase) != p) @(negedge clk);
    endtask

    // monitor: measures every timed phase and compares against the queue
    initial begin
        int last = 0;
        int run = 0;
        item_t it;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                last = 0;
                run  = 0;
            end else if (int'(phase) != last) begin
                if (last >= 1 && last <= 3) begin
                    if (expq.size() == 0) begin
                        check("R2 unexpected phase", last, 0);
                    end else begin
                        it = expq.pop_front();
                        check("R2 phase order", last, it.ph);
                        if (last == 2) check("R4 probe length", run, it.len);
                        else check("R3 silence length", run, it.len);
                    end
                end
                case (int'(phase))
                    1: begin
                        check("R7 forced_link off in PRE", int'(forced_link), 0);
                        check("R9 done cleared at PRE", int'(test_done), 0);
                    end
                    2: begin
                        check("R4 tx_en in PROBE", int'(tx_en), 1);
                        check("R5 amp_sel in PROBE", int'(amp_sel), int'(exp_amp));
                    end
                    3: begin
                        check("R4 tx_en off in POST", int'(tx_en), 0);
                        check("R5 amp_sel off in POST", int'(amp_sel), 0);
                        check("R7 done at POST", int'(test_done), 1);
                        check("R7 fail at POST", int'(test_fail), 0);
                    end
                    4: check("R7 forced_link in LINK", int'(forced_link), 1);
                    default: ;
                endcase
                last = int'(phase);
                run  = 1;
            end else begin
                run++;
            end
        end
    end

    task automatic run_test(input int pre, input int post, input int len, input int amp,
                            input int det, input int sgn, input int loc, input bit noisy);
        int d;
        item_t it;
        wr(1, (amp << 4) | (post << 2) | pre);
        wr(2, len);
        pk_detect = det[0];
        pk_sign   = sgn[0];
        pk_loc    = 10'(loc);
        exp_amp   = amp[0];
        it.ph = 1; it.len = quiet_cyc(pre);  expq.push_back(it);
        it.ph = 2; it.len = probe_cyc(len);  expq.push_back(it);
        it.ph = 3; it.len = quiet_cyc(post); expq.push_back(it);
        wr(0, 16'h8000);
        rd(0, d);
        check("R2 start bit pending", d, 16'h8000);
        rd(5, d);
        check("R9 result cleared by start", d, 0);
        @(negedge clk);
        check("R2 phase is PRE", int'(phase), 1);
        rd(0, d);
        check("R2 start bit self-cleared", d, 0);
        wait_phase(2);
        if (noisy) begin
            line_active = 1'b1;   // R10: no effect outside PRE
            wr(0, 16'h8000);      // R8: ignored while running
        end
        wait_phase(3);
        line_active = 1'b0;
        pk_detect = ~det[0];
        pk_sign   = ~sgn[0];
        pk_loc    = ~10'(loc);
        if (noisy) begin
            wr(0, 16'h8000);
            check("R8 done kept after start in POST", int'(test_done), 1);
            check("R8 still in POST", int'(phase), 3);
        end
        wait_phase(4);
        rd(5, d);
        check("R6 captured result", d, (det << 11) | (sgn << 10) | loc);
        rd(0, d);
        check("R7 control after test", d, 16'h0002);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int d;
        item_t it;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, d); check("R1 control reset", d, 0);
        rd(1, d); check("R1 timing reset", d, 0);
        rd(2, d); check("R1 probe length reset", d, 16000);
        rd(3, d); check("R1 tap word reset", d, 16'h2404);
        rd(4, d); check("R1 fault word reset", d, 16'h043E);
        rd(5, d); check("R1 result reset", d, 0);
        check("R1 phase reset", int'(phase), 0);
        check("R1 outputs reset", int'({tx_en, amp_sel, forced_link, test_done, test_fail}), 0);
        check("R11 tap outputs reset", int'({tap_last, tap_first}), (36 << 7) | 4);
        check("R11 fault outputs reset", int'({flt_offset, flt_thresh}), (4 << 8) | 62);

        // R11 field layout
        wr(3, 16'hFFFF);
        rd(3, d); check("R11 tap unused bits", d, 16'h7F7F);
        wr(3, (20 << 8) | 9);
        check("R11 tap_first", int'(tap_first), 9);
        check("R11 tap_last", int'(tap_last), 20);
        wr(4, 16'hFFFF);
        rd(4, d); check("R11 fault unused bits", d, 16'h7FFF);
        check("R11 flt_thresh", int'(flt_thresh), 255);
        wr(4, (11 << 8) | 77);
        check("R11 flt_offset", int'(flt_offset), 11);
        check("R11 flt_thresh value", int'(flt_thresh), 77);

        run_test(1, 1, 50, 0, 1, 1, 10'h2A5, 1'b0);   // open
        run_test(0, 2, 0, 1, 1, 0, 10'h3FF, 1'b1);    // short, restart from LINK
        run_test(3, 3, 300, 0, 0, 1, 10'h155, 1'b0);  // longest codes

        // R10 abort in the middle of pre-silence
        wr(1, 2);
        it.ph = 1; it.len = 10; expq.push_back(it);
        wr(0, 16'h8000);
        wait_phase(1);
        repeat (9) @(negedge clk);
        line_active = 1'b1;
        @(negedge clk);
        line_active = 1'b0;
        check("R10 abort returns to IDLE", int'(phase), 0);
        check("R10 done and fail on abort", int'({test_done, test_fail}), 3);
        check("R10 no forced link on abort", int'(forced_link), 0);
        rd(0, d); check("R10 control after abort", d, 3);
        rd(5, d); check("R10 result cleared on abort", d, 0);
        repeat (20) @(negedge clk);
        check("R10 stays IDLE", int'(phase), 0);

        run_test(0, 0, 7, 1, 1, 0, 5, 1'b0);          // zero silences
        repeat (5) @(negedge clk);
        check("R7 LINK held", int'(phase), 4);
        check("R2 all phases seen", expq.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule